// File: doc/BRIEF.md
# Memory Mat with Column Metadata Operations

This block is a single-ported storage mat of 512 words. Every word carries 32 bits of payload and a 4-bit metadata field. The metadata field holds per-line state such as valid, dirty, replacement and coherence bits when the mat serves as a cache tag or data store. When the mat serves as a queue, one metadata bit marks an entry as valid. Plain reads and writes pass through a two-stage pipeline, and the mat accepts a new command every cycle.

Two commands work on the metadata alone. A gang command sets or clears any chosen subset of the four metadata columns in every word at once, in a single cycle. A metadata update command reads one word's metadata and looks up its replacement in a 16-entry next-state table, which a configuration port loads. It writes the result back and returns it. If a later command in the pipeline touches the same word, it sees the update through forwarding. Results are applied in issue order, so any command stream behaves as if the commands ran one after another.

Top module: `meta_mat`

## Requirements
- R1: `cmd_i` encodes 0 idle, 1 read, 2 write, 3 gang, 4 metadata update, and values 5 to 7 act as idle. A write stores `wdata_i` and `wmeta_i` at `addr_i` (0 to 511). A later read of that address returns both values on `rdata_o` and `rmeta_o`, and this holds for a read issued in the very next cycle.
- R2: A read or metadata update issued at clock edge N raises `rvalid_o` after edge N+2, for exactly one cycle. A new command is accepted at every edge. Idle, write and gang commands never raise `rvalid_o`.
- R3: After reset, `rvalid_o` is low and every word's metadata is 0.
- R4: A gang command with `gang_set_i`=1 sets every metadata bit whose column bit in `mask_i` is 1, in all words. It leaves the other columns and all payload data unchanged.
- R5: A gang command with `gang_set_i`=0 clears every metadata bit whose column bit in `mask_i` is 1, in all words. It leaves the other columns and all payload data unchanged.
- R6: A gang command issued in cycle N is visible to a read issued in cycle N+1 or later.
- R7: A metadata update at `addr_i` replaces that word's metadata M with table entry M. The response carries the word's unchanged payload and the new metadata.
- R8: When `cfg_we_i` is high, the table entry indexed by `cfg_idx_i` takes `cfg_data_i`. After reset, entry k holds k, so an update leaves the metadata as it was.
- R9: A read or metadata update issued in the cycle right after a metadata update to the same address sees the updated metadata.
- R10: A write or gang command issued in the cycle right after a metadata update takes effect on top of that update. The later command wins for every bit it changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 3 | Command code |
| addr_i | input | 9 | Word address |
| wdata_i | input | 32 | Payload for writes |
| wmeta_i | input | 4 | Metadata for writes |
| mask_i | input | 4 | Column select for gang commands |
| gang_set_i | input | 1 | Gang polarity: 1 sets, 0 clears |
| cfg_we_i | input | 1 | Next-state table write enable |
| cfg_idx_i | input | 4 | Next-state table entry index |
| cfg_data_i | input | 4 | Next-state table entry value |
| rdata_o | output | 32 | Returned payload |
| rmeta_o | output | 4 | Returned metadata |
| rvalid_o | output | 1 | Response valid |

## Verification
Each read and metadata update must return its response exactly two edges after the edge that accepts it. Writes, gang commands and table loads produce no response; their effects show up in responses to reads issued one cycle later or after. The scoreboard stamps each expected response with its due cycle. It requires `rvalid_o` with the expected payload and metadata in that cycle only, and it flags a response in any other cycle. Back-to-back command pairs on the same address exercise the forwarding and ordering cases at the minimum one-cycle spacing.

// File: rtl/meta_mat_pkg.sv
package meta_mat_pkg;
  typedef enum logic [2:0] {
    CMD_IDLE  = 3'd0,
    CMD_READ  = 3'd1,
    CMD_WRITE = 3'd2,
    CMD_GANG  = 3'd3,
    CMD_RMW   = 3'd4
  } cmd_e;
endpackage

// File: rtl/meta_mat_data.sv
module meta_mat_data #(
  parameter int DEPTH  = 512,
  parameter int DATA_W = 32,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  // single port: write and read never coincide
  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
    if (re_i) rdata_o <= mem_q[addr_i];
  end
endmodule

// File: rtl/meta_mat_meta.sv
module meta_mat_meta #(
  parameter int DEPTH  = 512,
  parameter int META_W = 4,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wb_en_i,
  input  logic [AW-1:0]     wb_addr_i,
  input  logic [META_W-1:0] wb_meta_i,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [META_W-1:0] wr_meta_i,
  input  logic              gang_en_i,
  input  logic              gang_set_i,
  input  logic [META_W-1:0] mask_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [META_W-1:0] rd_meta_o
);
  logic [META_W-1:0] meta_arr [DEPTH];

  // priority per edge: update write-back, then the newer command
  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic [META_W-1:0] q, d;
    always_comb begin
      d = q;
      if (wb_en_i && wb_addr_i == AW'(g)) d = wb_meta_i;
      if (wr_en_i && wr_addr_i == AW'(g)) d = wr_meta_i;
      if (gang_en_i) d = gang_set_i ? (d | mask_i) : (d & ~mask_i);
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else         q <= d;
    end
    assign meta_arr[g] = q;
  end

  assign rd_meta_o = meta_arr[rd_addr_i];
endmodule

// File: rtl/meta_mat_nst.sv
module meta_mat_nst #(
  parameter int META_W = 4,
  localparam int N     = 1 << META_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [META_W-1:0] widx_i,
  input  logic [META_W-1:0] wdata_i,
  input  logic [META_W-1:0] ridx_i,
  output logic [META_W-1:0] rdata_o
);
  logic [META_W-1:0] tbl [N];

  for (genvar g = 0; g < N; g++) begin : g_row
    logic [META_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            q <= META_W'(g);
      else if (we_i && widx_i == META_W'(g))  q <= wdata_i;
    end
    assign tbl[g] = q;
  end

  assign rdata_o = tbl[ridx_i];
endmodule

// File: rtl/meta_mat.sv
module meta_mat
  import meta_mat_pkg::*;
#(
  parameter int DEPTH  = 512,
  parameter int DATA_W = 32,
  parameter int META_W = 4,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        cmd_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [META_W-1:0] wmeta_i,
  input  logic [META_W-1:0] mask_i,
  input  logic              gang_set_i,
  input  logic              cfg_we_i,
  input  logic [META_W-1:0] cfg_idx_i,
  input  logic [META_W-1:0] cfg_data_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [META_W-1:0] rmeta_o,
  output logic              rvalid_o
);
  logic is_rd, is_wr, is_gang, is_rmw;
  assign is_rd   = (cmd_i == CMD_READ);
  assign is_wr   = (cmd_i == CMD_WRITE);
  assign is_gang = (cmd_i == CMD_GANG);
  assign is_rmw  = (cmd_i == CMD_RMW);

  // stage 1: array access
  logic              s1_rd, s1_rmw;
  logic [AW-1:0]     s1_addr;
  logic [META_W-1:0] s1_meta, s1_nxt;
  logic [DATA_W-1:0] s1_data;
  logic [META_W-1:0] arr_meta, cur_meta;
  logic              fwd;

  meta_mat_data #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_data (
    .clk_i   (clk_i),
    .we_i    (is_wr),
    .re_i    (is_rd | is_rmw),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (s1_data)
  );

  meta_mat_meta #(.DEPTH(DEPTH), .META_W(META_W)) u_meta (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wb_en_i    (s1_rmw),
    .wb_addr_i  (s1_addr),
    .wb_meta_i  (s1_nxt),
    .wr_en_i    (is_wr),
    .wr_addr_i  (addr_i),
    .wr_meta_i  (wmeta_i),
    .gang_en_i  (is_gang),
    .gang_set_i (gang_set_i),
    .mask_i     (mask_i),
    .rd_addr_i  (addr_i),
    .rd_meta_o  (arr_meta)
  );

  meta_mat_nst #(.META_W(META_W)) u_nst (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .widx_i  (cfg_idx_i),
    .wdata_i (cfg_data_i),
    .ridx_i  (s1_meta),
    .rdata_o (s1_nxt)
  );

  // update write-back lands on the same edge this read samples: forward it
  assign fwd      = s1_rmw && (s1_addr == addr_i);
  assign cur_meta = fwd ? s1_nxt : arr_meta;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_rd   <= 1'b0;
      s1_rmw  <= 1'b0;
      s1_addr <= '0;
      s1_meta <= '0;
    end else begin
      s1_rd   <= is_rd;
      s1_rmw  <= is_rmw;
      s1_addr <= addr_i;
      if (is_rd || is_rmw) s1_meta <= cur_meta;
    end
  end

  // stage 2: peripheral / output
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
      rmeta_o  <= '0;
    end else begin
      rvalid_o <= s1_rd | s1_rmw;
      if (s1_rd || s1_rmw) begin
        rdata_o <= s1_data;
        rmeta_o <= s1_rmw ? s1_nxt : s1_meta;
      end
    end
  end
endmodule

// File: rtl/meta_mat_chk.sv
module meta_mat_chk
  import meta_mat_pkg::*;
#(
  parameter int DEPTH  = 512,
  parameter int DATA_W = 32,
  parameter int META_W = 4,
  localparam int AW    = $clog2(DEPTH)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [2:0]        cmd_i,
  input logic [AW-1:0]     addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [META_W-1:0] wmeta_i,
  input logic [META_W-1:0] mask_i,
  input logic              gang_set_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [META_W-1:0] rmeta_o,
  input logic              rvalid_o
);
  logic [1:0] live;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         live <= '0;
    else if (live != 2'd3) live <= live + 2'd1;
  end

  a_r2_resp_due: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_READ || cmd_i == CMD_RMW) |=> ##1 rvalid_o);

  a_r2_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_i == CMD_READ || cmd_i == CMD_RMW) |=> ##1 !rvalid_o);

  a_r1_write_then_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live != 2'd0 && cmd_i == CMD_READ && $past(cmd_i) == CMD_WRITE && $past(addr_i) == addr_i)
    |=> ##1 (rmeta_o == $past(wmeta_i, 3) && rdata_o == $past(wdata_i, 3)));

  a_r4_gang_set_seen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live != 2'd0 && cmd_i == CMD_READ && $past(cmd_i) == CMD_GANG && $past(gang_set_i))
    |=> ##1 ((rmeta_o & $past(mask_i, 3)) == $past(mask_i, 3)));

  a_r5_gang_clr_seen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live != 2'd0 && cmd_i == CMD_READ && $past(cmd_i) == CMD_GANG && !$past(gang_set_i))
    |=> ##1 ((rmeta_o & $past(mask_i, 3)) == '0));
endmodule

bind meta_mat meta_mat_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W), .META_W(META_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cmd_i      (cmd_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .wmeta_i    (wmeta_i),
  .mask_i     (mask_i),
  .gang_set_i (gang_set_i),
  .rdata_o    (rdata_o),
  .rmeta_o    (rmeta_o),
  .rvalid_o   (rvalid_o)
);

// File: tb/tb_meta_mat.sv
`timescale 1ns/1ps
module tb_meta_mat;
  localparam int DEPTH = 512;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cmd = 3'd0;
  logic [8:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [3:0]  wmeta = '0, mask = '0;
  logic        gset = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_idx = '0, cfg_data = '0;
  logic [31:0] rdata;
  logic [3:0]  rmeta;
  logic        rvalid;

  always #10 clk = ~clk;

  meta_mat dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_i(cmd), .addr_i(addr),
    .wdata_i(wdata), .wmeta_i(wmeta), .mask_i(mask), .gang_set_i(gset),
    .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx), .cfg_data_i(cfg_data),
    .rdata_o(rdata), .rmeta_o(rmeta), .rvalid_o(rvalid)
  );

  typedef struct {
    logic [31:0] d;
    logic [3:0]  m;
    bit          chk_d;
    int          due;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  logic [31:0] m_data [DEPTH];
  logic [3:0]  m_meta [DEPTH];
  bit          m_wr   [DEPTH];
  logic [3:0]  m_tbl  [16];
  int          cyc = 0;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: responses must appear exactly in their due cycle (R2)
  always @(negedge clk) begin
    if (rst_n) begin
      if (sb.size() > 0 && sb[0].due == cyc) begin
        checks++;
        if (!rvalid) begin
          errors++;
          $display("FAIL %s: rvalid act=0 exp=1 at cycle %0d", sb[0].tag, cyc);
        end else if (rmeta !== sb[0].m || (sb[0].chk_d && rdata !== sb[0].d)) begin
          errors++;
          $display("FAIL %s: act data=%h meta=%h exp data=%h meta=%h", sb[0].tag,
                   rdata, rmeta, sb[0].d, sb[0].m);
        end
        void'(sb.pop_front());
      end else if (rvalid) begin
        checks++;
        errors++;
        $display("FAIL R2: unexpected rvalid act=1 exp=0 at cycle %0d", cyc);
      end
    end
  end

  task automatic issue(input logic [2:0] c, input int a, input logic [31:0] d,
                       input logic [3:0] mt, input logic [3:0] mk, input bit st,
                       input string tag);
    exp_t e;
    cmd = c; addr = 9'(a); wdata = d; wmeta = mt; mask = mk; gset = st;
    case (c)
      3'd1: begin
        e = '{m_data[a], m_meta[a], m_wr[a], cyc + 2, tag};
        sb.push_back(e);
      end
      3'd2: begin
        m_data[a] = d; m_meta[a] = mt; m_wr[a] = 1'b1;
      end
      3'd3: begin
        for (int i = 0; i < DEPTH; i++)
          m_meta[i] = st ? (m_meta[i] | mk) : (m_meta[i] & ~mk);
      end
      3'd4: begin
        m_meta[a] = m_tbl[m_meta[a]];
        e = '{m_data[a], m_meta[a], m_wr[a], cyc + 2, tag};
        sb.push_back(e);
      end
      default: ;
    endcase
    @(negedge clk);
    cmd = 3'd0;
  endtask

  task automatic rd(input int a, input string tag);
    issue(3'd1, a, '0, '0, '0, 1'b0, tag);
  endtask
  task automatic wr(input int a, input logic [31:0] d, input logic [3:0] mt, input string tag);
    issue(3'd2, a, d, mt, '0, 1'b0, tag);
  endtask
  task automatic gang(input logic [3:0] mk, input bit st, input string tag);
    issue(3'd3, 0, '0, '0, mk, st, tag);
  endtask
  task automatic rmw(input int a, input string tag);
    issue(3'd4, a, '0, '0, '0, 1'b0, tag);
  endtask
  task automatic cfg(input int k, input logic [3:0] v);
    cfg_we = 1'b1; cfg_idx = 4'(k); cfg_data = v;
    m_tbl[k] = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: act=timeout exp=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      m_data[i] = '0; m_meta[i] = '0; m_wr[i] = 1'b0;
    end
    for (int k = 0; k < 16; k++) m_tbl[k] = 4'(k);

    repeat (3) @(negedge clk);
    checks++;
    if (rvalid !== 1'b0) begin
      errors++;
      $display("FAIL R3: rvalid in reset act=%b exp=0", rvalid);
    end
    rst_n = 1'b1;
    @(negedge clk);

    rd(7, "R3");                       // reset metadata is zero
    rd(300, "R3");

    wr(0,   32'hA5A5_0001, 4'h3, "R1");
    wr(1,   32'h1234_5678, 4'h9, "R1");
    wr(2,   32'hDEAD_BEEF, 4'hF, "R1");
    wr(511, 32'h0BAD_F00D, 4'h6, "R1");
    rd(511, "R1");                     // read right after write
    wr(300, 32'h0000_CAFE, 4'h0, "R1");
    rd(0, "R2"); rd(1, "R2"); rd(2, "R2"); rd(300, "R2");   // back-to-back
    issue(3'd6, 0, '0, '0, '0, 1'b0, "R1");                  // unused code is idle
    rd(1, "R1");

    rmw(2, "R8"); rmw(1, "R8");        // identity table after reset
    rd(2, "R8");

    gang(4'h5, 1'b1, "R4");
    rd(300, "R6"); rd(0, "R4"); rd(7, "R4"); rd(511, "R4");
    gang(4'h1, 1'b0, "R5");
    rd(2, "R6"); rd(1, "R5"); rd(300, "R5");

    for (int k = 0; k < 16; k++) cfg(k, 4'((k * 3 + 1) & 15));
    repeat (2) @(negedge clk);

    rmw(1, "R7");
    rd(1, "R9");                       // forwarded update
    rmw(1, "R9");
    rmw(1, "R9");
    rd(1, "R7");

    rmw(2, "R7");
    wr(2, 32'h7777_0002, 4'hA, "R10"); // write after update wins
    rd(2, "R10");

    rmw(0, "R7");
    gang(4'h8, 1'b1, "R10");           // gang on top of update
    rd(0, "R10");

    rmw(511, "R7");
    gang(4'hF, 1'b0, "R10");
    rd(511, "R10");

    cfg(0, 4'hC);
    rmw(300, "R8");
    rd(300, "R8");
    rmw(7, "R8");

    repeat (4) @(negedge clk);
    if (sb.size() != 0) begin
      checks++;
      errors++;
      $display("FAIL R2: pending responses act=%0d exp=0", sb.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule